// File: doc/BRIEF.md
# Serial-Bus Wiper Setting Slave

This block is a two-wire serial bus (I2C-compatible) target. It holds one 7-bit wiper setting and presents it on a parallel output to a resistor-ladder tap decoder. SCL and SDA are sampled by a system clock that runs at least eight times faster than SCL. The block recognises start and stop conditions and compares the first byte of each transfer with a 7-bit address set by a parameter. When the address matches, it acknowledges and then either accepts write bytes or returns the current setting. SDA is modelled as an open-drain pull-down enable: when `sda_pull_o` is high the line is held low.

A write transfer can carry any number of data bytes after one address. Each byte loads its low seven bits into the setting, and the top bit is ignored. A read returns a leading zero and then the seven setting bits, MSB first. While the master acknowledges, the same byte is sent again. After a reset the setting is midscale, 0x40.

Top module: `wiper_i2c_slave`

## Requirements
- R1: While reset is asserted and after it is released, `wiper_o` is 0x40 and `sda_pull_o` is low, until a write byte is accepted.
- R2: Start (SDA falling while SCL is high) begins a new address phase, including a repeated start in the middle of a transfer. Stop (SDA rising while SCL is high) ends any transfer and releases SDA.
- R3: After a start, the first 8 bits sampled on rising SCL are a 7-bit address (MSB first) followed by a direction bit (0 = write, 1 = read). If the address equals `SLAVE_ADDR`, `sda_pull_o` is high during the ninth SCL pulse.
- R4: On an address mismatch, SDA is never pulled, and no byte sent before the next start changes `wiper_o`.
- R5: In a write, each data byte is acknowledged on its ninth pulse. Bits 6..0 of the byte become `wiper_o` only after the falling SCL edge that ends that ninth pulse. Bit 7 is ignored.
- R6: After one address phase, every further write byte updates `wiper_o` again, until a stop or a start.
- R7: In a read, the block drives the bits {0, wiper[6:0]} MSB first. A driven 0 is `sda_pull_o` high; a 1 is the line released.
- R8: In a read, if the master acknowledges on the ninth pulse, the same byte is sent again. If the master does not acknowledge, SDA stays released until the next start or stop.
- R9: `sda_pull_o` changes only while SCL is low.
- R10: A start or stop part-way through a byte discards the partial byte, and `wiper_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Sensed level of the serial data line |
| sda_pull_o | output | 1 | High pulls SDA low (open-drain enable) |
| wiper_o | output | 7 | Current wiper setting to the tap decoder |

## Verification
Each bus edge reaches the protocol logic through two synchroniser flops and one edge-detect register. As a result, `sda_pull_o` moves three system cycles after the SCL falling edge that calls for it, and `wiper_o` changes three cycles after the falling edge that closes an accepting ninth pulse. The bench drives SDA five cycles into the SCL low phase and samples five cycles into the SCL high phase, which is fifteen cycles after the fall, well past that latency. It checks `wiper_o` five cycles after the final falling edge of a byte. To show that the update does not happen early, it also records `wiper_o` during the ninth high phase. A monitor counts any change of `sda_pull_o` while SCL is high.

// File: rtl/wiper_pkg.sv
`timescale 1ns/1ps
// Shared types for the wiper setting slave.
// Assumes: one byte on the bus is eight bits; the data field is at most seven.
package wiper_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start
        ST_ADDR,   // shifting in address and direction
        ST_AACK,   // acknowledging the address
        ST_WR,     // shifting in a write byte
        ST_WACK,   // acknowledging a write byte
        ST_RD,     // shifting out the setting
        ST_RACK    // sampling the master acknowledge
    } bus_st_t;
endpackage

// File: rtl/wiper_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser for asynchronous bus lines.
// Assumes: STAGES >= 2; reset value is the idle-high bus level.
module wiper_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/wiper_bus_cond.sv
`timescale 1ns/1ps
// Detects SCL edges and start/stop conditions from synchronised lines.
// Assumes: inputs already synchronised; SDA does not change on the same
// system cycle as SCL, which is true when the master obeys the bus setup and hold times.
module wiper_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    // Keep the previous sample of both lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/wiper_proto.sv
`timescale 1ns/1ps
// Bus protocol engine and wiper register.
// Assumes: event strobes come from wiper_bus_cond; stop wins over start.
// sda_pull_o is changed only on SCL falling edges or on start/stop.
module wiper_proto
    import wiper_pkg::*;
#(
    parameter int          DATA_W     = 7,
    parameter logic [6:0]  SLAVE_ADDR = 7'b0101110,
    parameter logic [DATA_W-1:0] PRESET = DATA_W'(1 << (DATA_W-1))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_pull_o,
    output logic [DATA_W-1:0] wiper_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    bus_st_t           st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sr;
    logic [BYTE_W-1:0] tx;
    logic              rw;
    logic              mack;
    logic              pull;
    logic [DATA_W-1:0] wiper_q;
    logic              byte_full;
    logic [BYTE_W-1:0] rd_word;

    assign byte_full = (cnt == CNT_W'(BYTE_W));
    assign rd_word   = {{(BYTE_W-DATA_W){1'b0}}, wiper_q};

    // Protocol state, bit counting, shifting and wiper update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            sr      <= '0;
            tx      <= '0;
            rw      <= 1'b0;
            mack    <= 1'b0;
            pull    <= 1'b0;
            wiper_q <= PRESET;
        end else if (stop_det) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            pull <= 1'b0;
        end else if (start_det) begin
            st   <= ST_ADDR;
            cnt  <= '0;
            pull <= 1'b0;
        end else begin
            case (st)
                ST_ADDR: begin
                    if (scl_rise && !byte_full) begin
                        sr  <= {sr[BYTE_W-2:0], sda_s};
                        cnt <= cnt + 1'b1;
                    end
                    if (scl_fall && byte_full) begin
                        if (sr[BYTE_W-1:1] == SLAVE_ADDR) begin
                            st   <= ST_AACK;
                            rw   <= sr[0];
                            pull <= 1'b1;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            st   <= ST_RD;
                            tx   <= rd_word;
                            pull <= ~rd_word[BYTE_W-1];
                        end else begin
                            st   <= ST_WR;
                            pull <= 1'b0;
                        end
                    end
                end
                ST_WR: begin
                    if (scl_rise && !byte_full) begin
                        sr  <= {sr[BYTE_W-2:0], sda_s};
                        cnt <= cnt + 1'b1;
                    end
                    if (scl_fall && byte_full) begin
                        st   <= ST_WACK;
                        pull <= 1'b1;
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        wiper_q <= sr[DATA_W-1:0];
                        pull    <= 1'b0;
                        cnt     <= '0;
                        st      <= ST_WR;
                    end
                end
                ST_RD: begin
                    if (scl_rise && !byte_full) cnt <= cnt + 1'b1;
                    if (scl_fall) begin
                        if (byte_full) begin
                            pull <= 1'b0;
                            st   <= ST_RACK;
                        end else begin
                            pull <= ~tx[BYTE_W-2];
                            tx   <= {tx[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) mack <= ~sda_s;
                    if (scl_fall) begin
                        cnt <= '0;
                        if (mack) begin
                            st   <= ST_RD;
                            tx   <= rd_word;
                            pull <= ~rd_word[BYTE_W-1];
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_pull_o = pull;
    assign wiper_o    = wiper_q;

    // R2: a stop always leaves the engine idle with SDA released
    assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == ST_IDLE && !pull));

    // R2: a start without stop opens an address phase
    assert_start_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (st == ST_ADDR));

    // R4: an idle engine never pulls SDA
    assert_idle_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !pull);

    // R4: mismatching address gets no acknowledge
    assert_no_ack_mismatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR && scl_fall && byte_full && !start_det && !stop_det &&
         sr[BYTE_W-1:1] != SLAVE_ADDR) |=> !pull);

    // R5: the setting moves only when a write acknowledge pulse ends
    assert_wiper_on_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wiper_q != $past(wiper_q)) |->
        $past(st == ST_WACK && scl_fall && !start_det && !stop_det));

    // R9: SDA is only newly pulled while SCL is low
    assert_pull_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull) |-> !scl_s);
endmodule

// File: rtl/wiper_i2c_slave.sv
`timescale 1ns/1ps
// Top: serial-bus slave owning one wiper setting register.
// Assumes: system clock >= 8x SCL; SDA is open drain, sda_pull_o high = low.
module wiper_i2c_slave #(
    parameter int         DATA_W     = 7,
    parameter logic [6:0] SLAVE_ADDR = 7'b0101110,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic [DATA_W-1:0] wiper_o
);
    logic [1:0] lines_s;
    logic scl_rise, scl_fall, start_det, stop_det;

    wiper_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({scl_i, sda_i}),
        .q    (lines_s)
    );

    wiper_bus_cond i_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (lines_s[1]),
        .sda_s    (lines_s[0]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    wiper_proto #(.DATA_W(DATA_W), .SLAVE_ADDR(SLAVE_ADDR)) i_proto (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (lines_s[1]),
        .sda_s     (lines_s[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_pull_o(sda_pull_o),
        .wiper_o   (wiper_o)
    );
endmodule

// File: tb/test_wiper_i2c_slave.sv
`timescale 1ns/1ps
// Self-checking bench: vector table of single-byte writes, then directed tests.
module test_wiper_i2c_slave;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 5;
    localparam int WDOG       = 100000;
    localparam logic [6:0] MY_ADDR = 7'h2E;
    localparam int NVEC = 6;
    // {pad, addr[6:0], data[7:0], ack_expected, wiper_expected[6:0]}
    localparam logic [23:0] VEC [NVEC] = '{
        {1'b0, 7'h2E, 8'h15, 1'b1, 7'h15},
        {1'b0, 7'h2E, 8'hFF, 1'b1, 7'h7F},
        {1'b0, 7'h2E, 8'h80, 1'b1, 7'h00},
        {1'b0, 7'h17, 8'h33, 1'b0, 7'h00},
        {1'b0, 7'h2F, 8'h44, 1'b0, 7'h00},
        {1'b0, 7'h2E, 8'h40, 1'b1, 7'h40}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic [6:0] wiper;
    logic sda_line;
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int viol = 0;
    logic prev_pull = 1'b0;
    logic [6:0] mid_wiper;

    assign sda_line = sda_m & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    wiper_i2c_slave i_wiper_i2c_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_pull_o(sda_pull),
        .wiper_o   (wiper)
    );

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog and SDA-change monitor (R9).
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && (sda_pull !== prev_pull) && scl) viol <= viol + 1;
        prev_pull <= sda_pull;
        if (cyc > WDOG) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=%0d expected<=%0d cycles", cyc, WDOG);
            finish_run();
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(QTR);
        scl = 1'b1;   tick(QTR);
        sda_m = 1'b0; tick(QTR);
        scl = 1'b0;   tick(QTR);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(QTR);
        scl = 1'b1;   tick(QTR);
        sda_m = 1'b1; tick(2*QTR);
    endtask

    // One SCL pulse with master bit b; returns the line level mid-high.
    task automatic clk_bit(input logic b, output logic seen);
        sda_m = b;  tick(QTR);
        scl = 1'b1; tick(QTR);
        seen = sda_line;
        mid_wiper = wiper;
        tick(QTR);
        scl = 1'b0; tick(QTR);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            v[i] = s;
        end
        clk_bit(~mack, s);
    endtask

    initial begin
        logic ack;
        logic s;
        logic [7:0] rd;
        logic [23:0] v;

        tick(4);
        chk("R1 reset wiper", wiper, 7'h40);
        chk("R1 reset sda released", sda_pull, 0);
        rst_n = 1'b1;
        tick(4);
        chk("R1 wiper after reset", wiper, 7'h40);

        // Vector table: one byte per transfer
        for (int i = 0; i < NVEC; i++) begin
            v = VEC[i];
            bus_start();
            send_byte({v[22:16], 1'b0}, ack);
            chk(v[7] ? "R3 address ack" : "R4 address no ack", ack, v[7]);
            send_byte(v[15:8], ack);
            chk(v[7] ? "R5 data ack" : "R4 data no ack", ack, v[7]);
            bus_stop();
            chk(v[7] ? "R5 wiper low 7 bits" : "R4 wiper unchanged", wiper, v[6:0]);
        end

        // R6 several bytes after one address; R5 update only after ninth pulse
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        chk("R3 address ack multi", ack, 1);
        send_byte(8'h01, ack);
        chk("R5 wiper held during ninth pulse", mid_wiper, 7'h40);
        chk("R6 first byte", wiper, 7'h01);
        send_byte(8'hFE, ack);
        chk("R5 wiper held during ninth pulse 2", mid_wiper, 7'h01);
        chk("R6 second byte", wiper, 7'h7E);
        send_byte(8'h23, ack);
        chk("R6 third byte ack", ack, 1);
        chk("R6 third byte", wiper, 7'h23);
        bus_stop();

        // R7 read with master ACK then NACK (R8)
        bus_start();
        send_byte({MY_ADDR, 1'b1}, ack);
        chk("R3 read address ack", ack, 1);
        read_byte(1'b1, rd);
        chk("R7 read byte", rd, 8'h23);
        read_byte(1'b0, rd);
        chk("R8 repeated after master ack", rd, 8'h23);
        read_byte(1'b0, rd);
        chk("R8 released after nack", rd, 8'hFF);
        bus_stop();

        // R2 repeated start: write then read back in one session
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        send_byte(8'h5A, ack);
        bus_start();
        send_byte({MY_ADDR, 1'b1}, ack);
        chk("R2 repeated start address ack", ack, 1);
        read_byte(1'b0, rd);
        chk("R2 read after repeated start", rd, 8'h5A);
        bus_stop();

        // R10 partial byte cut by stop
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
        bus_stop();
        chk("R10 partial byte then stop", wiper, 7'h5A);

        // R10 partial byte cut by start, then a full write
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        for (int i = 0; i < 3; i++) clk_bit(1'b1, s);
        chk("R10 partial byte then start", wiper, 7'h5A);
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        chk("R2 address after mid-byte start", ack, 1);
        send_byte(8'h11, ack);
        bus_stop();
        chk("R2 write after mid-byte start", wiper, 7'h11);

        // R4 mismatch then write bytes stay ignored until a new start
        bus_start();
        send_byte({7'h16, 1'b0}, ack);
        chk("R4 alternate address no ack", ack, 0);
        send_byte(8'h7F, ack);
        send_byte(8'h05, ack);
        bus_stop();
        chk("R4 wiper kept after mismatch", wiper, 7'h11);

        chk("R9 pull changed while SCL high", viol, 0);

        // R1 reset in the middle of a transfer restores midscale
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        send_byte(8'h30, ack);
        rst_n = 1'b0;
        tick(3);
        chk("R1 midscale on reset", wiper, 7'h40);
        chk("R1 released on reset", sda_pull, 0);
        rst_n = 1'b1;
        bus_stop();

        finish_run();
    end
endmodule